// File: doc/BRIEF.md
# Phase-Checked SCSI Byte Mover

This block copies a run of bytes between a byte-wide memory port and the byte-wide data path of a SCSI bus. It is used in two steps. First, a setup strobe loads a 24-bit byte count and a 24-bit start address. Then a control strobe with its go bit set starts the run, and a direction bit picks which way the bytes flow.

The engine moves the bytes one at a time. For each byte it completes a memory cycle and a full REQ/ACK handshake with the target, in the order the direction requires. After each byte it steps the count down by one and the address up by one.

At the start of a run the engine latches the bus phase it expects. Before every byte it compares that value with the live bus phase. If the two differ, the run ends at once. The byte in hand is not moved, and the count and address keep the values they had, so control logic can see how far the run got. Every end of a run, whether completed or cut short, gives a single done pulse. A count-zero flag shows whether any bytes remain.

Top module: `phase_dma_engine`

## Requirements
- R1: A control strobe (`ctl_we`) with `ctl_go`=1, given while the engine is idle, starts a run. `busy` is 1 in the next cycle. `ctl_to_scsi`=1 moves bytes from memory to SCSI, and 0 moves bytes from SCSI to memory.
- R2: Each byte that is moved lowers `count_out` by exactly one and raises `mem_addr` by exactly one. `mem_addr` is the address of the byte currently being moved.
- R3: Before each byte, the engine compares `bus_phase` with the `exp_phase` value latched at start. On a mismatch the run stops. No memory cycle and no `scsi_ack` is issued for that byte, and the count and address keep their values.
- R4: Every end of a run, by completion or by abort, gives `done`=1 for exactly one cycle. `busy` is 0 in the cycle after `done`.
- R5: `count_zero` is 1 exactly when the remaining count is zero. This holds after a setup load, after reset and after each byte.
- R6: A start with a zero count gives `done` in the next cycle and issues no `mem_req` and no `scsi_ack`.
- R7: While `busy` is 1, control strobes and setup strobes have no effect. The count, the address and the direction of the running transfer are unchanged.
- R8: Each byte waits for both handshakes.
  - Memory to SCSI: the engine holds a read (`mem_req`=1, `mem_we`=0) until `mem_ack`. It then drives the byte on `scsi_dout`, waits for `scsi_req`=1, raises `scsi_ack`, and holds it until `scsi_req` falls.
  - SCSI to memory: the engine waits for `scsi_req`, captures `scsi_din` and acknowledges it. It then holds a write (`mem_req`=1, `mem_we`=1) until `mem_ack`.
- R9: After a synchronous reset: `busy`=0, `done`=0, `mem_req`=0, `scsi_ack`=0, `count_out`=0, `mem_addr`=0 and `count_zero`=1.
- R10: Bytes arrive at the destination in address order, and each byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_we | input | 1 | Load count and address (ignored while busy) |
| setup_count | input | 24 | Byte count to load |
| setup_addr | input | 24 | Start address to load |
| ctl_we | input | 1 | Control strobe |
| ctl_go | input | 1 | Start bit of the control strobe |
| ctl_to_scsi | input | 1 | 1: memory to SCSI, 0: SCSI to memory |
| exp_phase | input | 3 | Expected bus phase, latched at start |
| bus_phase | input | 3 | Live bus phase |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 24 | Current address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory |
| mem_ack | input | 1 | Memory cycle complete |
| scsi_req | input | 1 | Target REQ |
| scsi_ack | output | 1 | Initiator ACK |
| scsi_din | input | 8 | Byte from the target |
| scsi_dout | output | 8 | Byte to the target |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| count_zero | output | 1 | Remaining count is zero |
| count_out | output | 24 | Remaining count |

## Verification
A corrupt count or address register shows up at the end of the run. `count_out` and `mem_addr` no longer match the number of handshakes the target model counted, and the bench compares them on the same cycle `done` rises. A sequencer that skips the phase check or a handshake wait has a different effect: a byte that should not have moved appears in memory, or appears in the capture buffer of the SCSI model. This is visible within a few cycles of the abort. A stuck or stretched `done` is caught one cycle after it rises.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  // Sequencer states, one per step of a byte move
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CHECK    = 3'd1,
    ST_MEM_RD   = 3'd2,
    ST_REQ_WAIT = 3'd3,
    ST_REQ_REL  = 3'd4,
    ST_MEM_WR   = 3'd5,
    ST_STEP     = 3'd6,
    ST_DONE     = 3'd7
  } dma_state_e;

endpackage

// File: rtl/dma_phase_gate.sv
module dma_phase_gate #(
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [PHASE_W-1:0] exp_in,
  input  logic [PHASE_W-1:0] bus_phase,
  output logic               phase_ok
);

  logic [PHASE_W-1:0] exp_q;

  // Expected phase is frozen for the whole run
  always_ff @(posedge clk) begin
    if (rst)
      exp_q <= '0;
    else if (capture)
      exp_q <= exp_in;
  end

  // Live comparison, evaluated by the sequencer before every byte
  assign phase_ok = (exp_q == bus_phase);

endmodule

// File: rtl/dma_cnt_addr.sv
module dma_cnt_addr #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              step,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              cnt_zero_q,
  output logic              cnt_one
);

  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)
      cnt_n = cnt_in;
    else if (step)
      cnt_n = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      addr_q     <= '0;
      cnt_zero_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_n;
      cnt_zero_q <= (cnt_n == '0);
      if (load)
        addr_q <= addr_in;
      else if (step)
        addr_q <= addr_q + ADDR_ONE;
    end
  end

  assign cnt_one = (cnt_q == CNT_ONE);

  // R2: one byte step moves count and address by exactly one
  p_step_math_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cnt_q == $past(cnt_q) - CNT_ONE) && (addr_q == $past(addr_q) + ADDR_ONE));

  // R2: the sequencer never steps an exhausted count
  p_step_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt_q != '0));

  // R5: registered zero flag tracks the count register
  p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_zero_q == (cnt_q == '0));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_eng_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic to_scsi_in,
  input  logic cnt_zero,
  input  logic cnt_one,
  input  logic phase_ok,
  input  logic mem_ack,
  input  logic scsi_req,
  output logic busy,
  output logic done,
  output logic mem_req,
  output logic mem_we,
  output logic scsi_ack,
  output logic step,
  output logic grab_mem,
  output logic grab_scsi,
  output logic dir_q
);

  dma_state_e st, st_n;

  always_comb begin
    st_n = st;
    case (st)
      ST_IDLE:     if (start) st_n = cnt_zero ? ST_DONE : ST_CHECK;
      ST_CHECK:    if (!phase_ok) st_n = ST_DONE;
                   else           st_n = dir_q ? ST_MEM_RD : ST_REQ_WAIT;
      ST_MEM_RD:   if (mem_ack) st_n = ST_REQ_WAIT;
      ST_REQ_WAIT: if (scsi_req) st_n = ST_REQ_REL;
      ST_REQ_REL:  if (!scsi_req) st_n = dir_q ? ST_STEP : ST_MEM_WR;
      ST_MEM_WR:   if (mem_ack) st_n = ST_STEP;
      ST_STEP:     st_n = cnt_one ? ST_DONE : ST_CHECK;
      ST_DONE:     st_n = ST_IDLE;
      default:     st_n = ST_IDLE;
    endcase
  end

  // State and registered port-facing outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      dir_q    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      scsi_ack <= 1'b0;
    end else begin
      st       <= st_n;
      if (st == ST_IDLE && start)
        dir_q <= to_scsi_in;
      busy     <= (st_n != ST_IDLE);
      done     <= (st_n == ST_DONE);
      mem_req  <= (st_n == ST_MEM_RD) || (st_n == ST_MEM_WR);
      mem_we   <= (st_n == ST_MEM_WR);
      scsi_ack <= (st_n == ST_REQ_REL);
    end
  end

  assign step      = (st == ST_STEP);
  assign grab_mem  = (st == ST_MEM_RD) && mem_ack;
  assign grab_scsi = (st == ST_REQ_WAIT) && scsi_req && !dir_q;

  // R3: a phase mismatch ends the run without touching either bus
  p_abort_clean_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && !phase_ok) |=> (done && !mem_req && !scsi_ack));

  // R4: done lasts one cycle and the engine is idle right after
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R6: zero-count start skips every bus cycle
  p_zero_start_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start && cnt_zero) |=> (done && !mem_req && !scsi_ack));

  // R7: direction is frozen while a run is active
  p_dir_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(dir_q));

  // R8: ACK only rises in answer to REQ
  p_ack_after_req_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(scsi_ack) |-> $past(scsi_req));

  // R8: a memory request is held until acknowledged
  p_mem_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> mem_req);

endmodule

// File: rtl/phase_dma_engine.sv
module phase_dma_engine #(
  parameter int CNT_W   = 24,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               setup_we,
  input  logic [CNT_W-1:0]   setup_count,
  input  logic [ADDR_W-1:0]  setup_addr,
  input  logic               ctl_we,
  input  logic               ctl_go,
  input  logic               ctl_to_scsi,
  input  logic [PHASE_W-1:0] exp_phase,
  input  logic [PHASE_W-1:0] bus_phase,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_ack,
  input  logic               scsi_req,
  output logic               scsi_ack,
  input  logic [DATA_W-1:0]  scsi_din,
  output logic [DATA_W-1:0]  scsi_dout,
  output logic               busy,
  output logic               done,
  output logic               count_zero,
  output logic [CNT_W-1:0]   count_out
);

  logic start, load, step, cnt_one, phase_ok;
  logic grab_mem, grab_scsi, dir_q;
  logic [DATA_W-1:0] byte_q;

  // Strobes act only while idle
  assign start = ctl_we && ctl_go && !busy;
  assign load  = setup_we && !busy;

  dma_phase_gate #(.PHASE_W(PHASE_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .capture   (start),
    .exp_in    (exp_phase),
    .bus_phase (bus_phase),
    .phase_ok  (phase_ok)
  );

  dma_cnt_addr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .cnt_in     (setup_count),
    .addr_in    (setup_addr),
    .step       (step),
    .cnt_q      (count_out),
    .addr_q     (mem_addr),
    .cnt_zero_q (count_zero),
    .cnt_one    (cnt_one)
  );

  dma_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .to_scsi_in (ctl_to_scsi),
    .cnt_zero   (count_zero),
    .cnt_one    (cnt_one),
    .phase_ok   (phase_ok),
    .mem_ack    (mem_ack),
    .scsi_req   (scsi_req),
    .busy       (busy),
    .done       (done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .scsi_ack   (scsi_ack),
    .step       (step),
    .grab_mem   (grab_mem),
    .grab_scsi  (grab_scsi),
    .dir_q      (dir_q)
  );

  // Single byte holding register shared by both directions
  always_ff @(posedge clk) begin
    if (rst)
      byte_q <= '0;
    else if (grab_mem)
      byte_q <= mem_rdata;
    else if (grab_scsi)
      byte_q <= scsi_din;
  end

  assign scsi_dout = byte_q;
  assign mem_wdata = byte_q;

  // R1: an accepted start raises busy on the next cycle
  p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_go && !busy) |=> busy);

  // R7: setup strobes during a run leave the address alone unless a byte steps
  p_setup_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && setup_we && !step) |=> $stable(mem_addr));

endmodule

// File: tb/phase_dma_engine_tb.sv
module phase_dma_engine_tb;

  localparam int CW = 24, AW = 24, DW = 8, PW = 3;
  localparam logic [PW-1:0] PH_OK  = 3'b010;
  localparam logic [PW-1:0] PH_BAD = 3'b011;
  localparam int MEM_LAT = 2;
  localparam int NV = 6;
  // {to_scsi, count, base, abort_after (255 = none)}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'd4, 8'h10, 8'hFF},
    {1'b0, 8'd5, 8'h40, 8'hFF},
    {1'b1, 8'd6, 8'h60, 8'd2},
    {1'b0, 8'd3, 8'h80, 8'd0},
    {1'b0, 8'd7, 8'hA0, 8'd5},
    {1'b1, 8'd1, 8'hC0, 8'hFF}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic setup_we = 1'b0, ctl_we = 1'b0, ctl_go = 1'b0, ctl_to_scsi = 1'b0;
  logic [CW-1:0] setup_count = '0;
  logic [AW-1:0] setup_addr = '0;
  logic [PW-1:0] exp_phase = PH_OK;
  logic [PW-1:0] bus_phase;
  logic mem_req, mem_we, scsi_ack, busy, done, count_zero;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, scsi_dout;
  logic [CW-1:0] count_out;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_ack = 1'b0;
  logic scsi_req = 1'b0;
  logic [DW-1:0] scsi_din = '0;

  int errors = 0, checks = 0;

  phase_dma_engine u_dut (
    .clk(clk), .rst(rst), .setup_we(setup_we), .setup_count(setup_count),
    .setup_addr(setup_addr), .ctl_we(ctl_we), .ctl_go(ctl_go),
    .ctl_to_scsi(ctl_to_scsi), .exp_phase(exp_phase), .bus_phase(bus_phase),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .scsi_req(scsi_req), .scsi_ack(scsi_ack), .scsi_din(scsi_din),
    .scsi_dout(scsi_dout), .busy(busy), .done(done),
    .count_zero(count_zero), .count_out(count_out)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model with fixed latency; also flags requests dropped before ack
  logic [7:0] mem [256];
  logic fill_now = 1'b0;
  int lat = 0, mem_viol = 0;
  logic prev_req = 1'b0, prev_ack = 1'b0;
  always @(negedge clk) begin
    if (prev_req && !prev_ack && !mem_req) mem_viol++;
    if (fill_now) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    end
    if (mem_req && !mem_ack) begin
      if (lat == MEM_LAT) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[7:0]];
        lat = 0;
      end else lat++;
    end else if (!mem_req) begin
      mem_ack = 1'b0;
      lat = 0;
    end
    prev_req = mem_req;
    prev_ack = mem_ack;
  end

  // SCSI target model
  logic tgt_en = 1'b0;
  int tgt_cnt = 0, tgt_limit = 0, abort_at = 1000, scsi_viol = 0;
  logic prev_sack = 1'b0;
  logic [7:0] cap [256];
  always @(negedge clk) begin
    if (scsi_ack && !prev_sack && !scsi_req) scsi_viol++;
    prev_sack = scsi_ack;
    if (!tgt_en) begin
      scsi_req = 1'b0;
      tgt_cnt = 0;
    end else if (scsi_req && scsi_ack) begin
      cap[tgt_cnt[7:0]] = scsi_dout;
      scsi_req = 1'b0;
      tgt_cnt++;
    end else if (!scsi_req && !scsi_ack && tgt_cnt < tgt_limit) begin
      scsi_din = 8'hC3 ^ 8'(tgt_cnt);
      scsi_req = 1'b1;
    end
  end

  always_comb bus_phase = (tgt_cnt == abort_at) ? PH_BAD : PH_OK;

  task automatic wait_done();
    int g = 0;
    while (!done && g < 3000) begin
      @(negedge clk);
      g++;
    end
    chk(done == 1'b1, "R4 done never seen", done, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R4 actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    fill_now = 1'b1;
    repeat (3) @(negedge clk);
    fill_now = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!busy && !done, "R9 busy/done", {busy, done}, 0);
    chk(!mem_req && !scsi_ack, "R9 bus idle", {mem_req, scsi_ack}, 0);
    chk(count_out == 0 && mem_addr == 0, "R9 count/addr", count_out, 0);
    chk(count_zero == 1'b1, "R9 count_zero", count_zero, 1);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      automatic logic [24:0] vv = VEC[v];
      automatic logic d = vv[24];
      automatic int cnt = int'(vv[23:16]);
      automatic int base = int'(vv[15:8]);
      automatic int ab = (vv[7:0] == 8'hFF) ? 1000 : int'(vv[7:0]);
      automatic int moved = (ab < cnt) ? ab : cnt;
      automatic int bad = 0;
      tgt_en = 1'b0;
      @(negedge clk);
      abort_at = ab;
      tgt_limit = cnt;
      tgt_en = 1'b1;
      setup_we = 1'b1; setup_count = CW'(cnt); setup_addr = AW'(base);
      @(negedge clk);
      setup_we = 1'b0;
      chk(count_zero == 1'b0, "R5 flag after load", count_zero, 0);
      ctl_we = 1'b1; ctl_go = 1'b1; ctl_to_scsi = d;
      @(negedge clk);
      ctl_we = 1'b0; ctl_go = 1'b0;
      chk(busy == 1'b1, "R1 busy after start", busy, 1);
      wait_done();
      chk(count_out == CW'(cnt - moved), "R2 R3 remaining count", count_out, cnt - moved);
      chk(mem_addr == AW'(base + moved), "R2 R3 final address", mem_addr, base + moved);
      chk(count_zero == (cnt == moved), "R5 count_zero at end", count_zero, cnt == moved);
      chk(tgt_cnt == moved, "R8 R3 handshakes", tgt_cnt, moved);
      for (int i = 0; i < moved; i++) begin
        if (d) begin
          if (cap[i] != (8'(base + i) ^ 8'h5A)) bad++;
        end else begin
          if (mem[8'(base + i)] != (8'hC3 ^ 8'(i))) bad++;
        end
      end
      chk(bad == 0, "R10 data order/value", bad, 0);
      if (!d)
        chk(mem[8'(base + moved)] == (8'(base + moved) ^ 8'h5A), "R3 no extra write",
            mem[8'(base + moved)], 8'(base + moved) ^ 8'h5A);
      @(negedge clk);
      chk(!done && !busy, "R4 one-cycle done", {done, busy}, 0);
    end

    // R6: zero-count start
    tgt_en = 1'b0;
    setup_we = 1'b1; setup_count = '0; setup_addr = AW'(24'h33);
    @(negedge clk);
    setup_we = 1'b0;
    chk(count_zero == 1'b1, "R5 flag after zero load", count_zero, 1);
    ctl_we = 1'b1; ctl_go = 1'b1; ctl_to_scsi = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0; ctl_go = 1'b0;
    chk(done == 1'b1, "R6 immediate done", done, 1);
    chk(!mem_req && !scsi_ack, "R6 no bus cycle", {mem_req, scsi_ack}, 0);
    chk(mem_addr == AW'(24'h33), "R6 address kept", mem_addr, 24'h33);
    @(negedge clk);
    chk(!done && !busy, "R4 zero run ends", {done, busy}, 0);

    // R7: strobes during a stalled run
    setup_we = 1'b1; setup_count = CW'(3); setup_addr = AW'(24'hE0);
    @(negedge clk);
    setup_we = 1'b0;
    ctl_we = 1'b1; ctl_go = 1'b1; ctl_to_scsi = 1'b0;
    @(negedge clk);
    ctl_we = 1'b0; ctl_go = 1'b0;
    @(negedge clk);
    setup_we = 1'b1; setup_count = CW'(9); setup_addr = AW'(24'h10);
    ctl_we = 1'b1; ctl_go = 1'b1; ctl_to_scsi = 1'b1;
    @(negedge clk);
    setup_we = 1'b0; ctl_we = 1'b0; ctl_go = 1'b0;
    repeat (4) @(negedge clk);
    chk(count_out == CW'(3) && mem_addr == AW'(24'hE0), "R7 setup ignored", count_out, 3);
    chk(busy == 1'b1 && mem_req == 1'b0, "R7 restart ignored", {busy, mem_req}, 2);
    abort_at = 1000; tgt_limit = 3; tgt_en = 1'b1;
    wait_done();
    begin
      automatic int bad = 0;
      for (int i = 0; i < 3; i++)
        if (mem[8'(8'hE0 + i)] != (8'hC3 ^ 8'(i))) bad++;
      chk(bad == 0, "R7 direction kept", bad, 0);
    end
    chk(count_out == 0, "R7 run completes", count_out, 0);
    @(negedge clk);

    chk(mem_viol == 0, "R8 memory request held to ack", mem_viol, 0);
    chk(scsi_viol == 0, "R8 ack follows req", scsi_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule